// File: doc/BRIEF.md
# Up-Counting Reloadable Interval Timer

This block is a word-register timer peripheral. A 32-bit counter advances by one on every cycle where the prescaled tick-enable input is high and the run bit is set. It counts upward and overflows when it passes from all-ones to zero. To get a period of N ticks, software writes the two's complement of N into the load register and the counter. On overflow the counter either reloads from the load register or stops at zero, and an overflow status bit is raised. A compare unit raises a second status bit while the counter equals a programmed match value.

Software works through a simple register bus, with one write or read per cycle and read data returned in the same cycle. It can overwrite the counter while it runs, or force a reload by writing the trigger register. Each status bit is cleared by writing a one to it. A software-requested reset runs a short internal sequence, then clears the control and interrupt-enable registers and reports completion. The interrupt output is a level that stays high while any enabled status bit is set.

Top module: `uptick_timer`

## Requirements
- R1: While control bit 0 (run) is set, the counter (offset 0x28) increases by exactly one at each clock edge where tick_en is 1. With run clear, or tick_en low, the counter holds its value.
- R2: When a running counter at 0xFFFFFFFF takes a tick with control bit 1 (autoreload) set, it takes the value of the load register (offset 0x2C). Interrupt-status bit 1 (overflow, offset 0x18) is set at the same edge. A load value of 2^32-N gives a period of N ticks.
- R3: When the same wrap happens with autoreload clear, the counter becomes 0, control bit 0 clears, and no further counting happens. Overflow status bit 1 is still set.
- R4: A write to the counter offset replaces the count at that edge, takes priority over a tick in the same cycle, and counting continues from the written value.
- R5: A write of any data to the trigger offset 0x30 copies the load register into the counter.
- R6: With control bit 6 (compare enable) set, interrupt-status bit 0 (match) is set at the edge that ends a cycle in which the counter equals the match register (offset 0x38). With bit 6 clear, the match bit is never set.
- R7: Writing interrupt status with a 1 in a bit position clears that bit, and writing 0 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R8: irq is high whenever any interrupt-status bit is 1 and its interrupt-enable bit (offset 0x1C, bit 1 overflow, bit 0 match) is also 1. irq stays high until the status bit or the enable bit is cleared.
- R9: Writing config (offset 0x10) with bit 1 set starts a soft reset. Reset-done, bit 0 of status (offset 0x14), reads 0 for exactly 4 cycles and then 1. Config bit 1 reads 1 while the reset is in progress and 0 afterwards. Control and interrupt enable read 0 once it completes.
- R10: After rst_n, all registers read 0 except reset-done, which reads 1, and irq is low. The trigger offset, the write-pending offset 0x34 and unmapped offsets read 0. The wake-enable register (offset 0x20) reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq | output | 1 | Level interrupt request |

## Verification
A write takes effect at the edge that closes its bus cycle, and a read returns the current register value in the same cycle. Counter changes from ticks, wraps, triggers and counter writes are visible in the cycle after the edge that caused them. A status bit is set one edge after its condition holds, and irq follows the status and enable bits with no added delay. The driver issues each access in its own cycle and queues the expected value at that point. The monitor pops and compares that value late in the same cycle, after all edge updates have settled. Where a result is due one cycle later, such as a match status or the fourth cycle of soft reset, the driver places an extra read or idle cycle so the comparison lands on the right cycle.

// File: rtl/uptick_pkg.sv
// Shared constants for the up-counting timer: register offsets and the bit
// positions that software relies on. Assumes byte offsets on an 8-bit bus.
package uptick_pkg;
    localparam logic [7:0] OFF_CFG   = 8'h10;
    localparam logic [7:0] OFF_STAT  = 8'h14;
    localparam logic [7:0] OFF_ISR   = 8'h18;
    localparam logic [7:0] OFF_IER   = 8'h1C;
    localparam logic [7:0] OFF_WAKE  = 8'h20;
    localparam logic [7:0] OFF_CTL   = 8'h24;
    localparam logic [7:0] OFF_CNT   = 8'h28;
    localparam logic [7:0] OFF_LOAD  = 8'h2C;
    localparam logic [7:0] OFF_TRIG  = 8'h30;
    localparam logic [7:0] OFF_PEND  = 8'h34;
    localparam logic [7:0] OFF_MATCH = 8'h38;

    localparam int CTL_RUN  = 0;
    localparam int CTL_AUTO = 1;
    localparam int CTL_CMP  = 6;
    localparam int IRQ_MAT  = 0;
    localparam int IRQ_OVF  = 1;
    localparam int IRQ_NUM  = 2;
    localparam int CFG_SRST = 1;
    localparam int STAT_DONE = 0;

    typedef struct packed {
        logic cmp_en;
        logic auto_rl;
        logic run;
    } ctl_t;
endpackage

// File: rtl/uptick_core.sv
// Counter core: counts up on tick while running. At an all-ones wrap it
// either reloads or drops to zero. Also reports equality with the match value.
// Assumes at most one of cnt_wr / trig is meaningful; cnt_wr wins if both.
module uptick_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         run,
    input  logic         auto_rl,
    input  logic         cmp_en,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         trig,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         mat_evt
);
    localparam logic [W-1:0] ALL1 = '1;

    logic step;

    // Decide whether this cycle advances the count and whether it wraps.
    always_comb begin
        step    = run && tick_en && !cnt_wr && !trig;
        ovf_evt = step && (cnt == ALL1);
        mat_evt = cmp_en && (cnt == match_val);
    end

    // Counter register: software write, trigger reload, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt_wr)     cnt <= cnt_wdata;
        else if (trig)       cnt <= load_val;
        else if (ovf_evt)    cnt <= auto_rl ? load_val : '0;
        else if (step)       cnt <= cnt + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !cnt_wr && !trig && cnt != ALL1) |=> cnt == $past(cnt) + 1'b1); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick_en) && !cnt_wr && !trig) |=> $stable(cnt)); // R1
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && auto_rl && !cnt_wr && !trig && cnt == ALL1) |=> cnt == $past(load_val)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !auto_rl && !cnt_wr && !trig && cnt == ALL1) |=> cnt == '0); // R3
    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(cnt_wdata)); // R4
    AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !cnt_wr) |=> cnt == $past(load_val)); // R5
endmodule

// File: rtl/uptick_intc.sv
// Interrupt status and request: sticky status bits set by events and cleared
// by write-one. A set in the same cycle beats a clear. The request is a level.
module uptick_intc #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] ien,
    output logic [N-1:0] isr,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One status bit: set wins, else write-one clears, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)                       isr[i] <= 1'b0;
            else if (set_evt[i])              isr[i] <= 1'b1;
            else if (clr_wr && clr_mask[i])   isr[i] <= 1'b0;
        end
    end

    // Level request from enabled status bits.
    always_comb irq = |(isr & ien);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && set_evt == '0) |=> (isr & $past(clr_mask)) == '0); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt != '0) |=> (isr & $past(set_evt)) == $past(set_evt)); // R7
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt == '0 && (!clr_wr || clr_mask == '0)) |=> $stable(isr)); // R7
endmodule

// File: rtl/uptick_softrst.sv
// Soft-reset sequencer: a request starts a fixed-length countdown. On its last
// cycle a one-cycle fire pulse clears the owner's registers. Requests that
// arrive while busy are ignored.
module uptick_softrst #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic fire
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] left;

    // Countdown of remaining sequence cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              left <= '0;
        else if (req && !busy)   left <= CW'(CYC);
        else if (left != '0)     left <= left - 1'b1;
    end

    // Status decode of the countdown.
    always_comb begin
        busy = (left != '0);
        fire = (left == CW'(1));
    end

    AST_SR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy); // R9
    AST_SR_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req) |=> !busy); // R9
endmodule

// File: rtl/uptick_timer.sv
// Top of the up-counting timer: register decode, control storage, read mux.
// Assumes one access per cycle with combinational read data. Offsets and bit
// positions come from uptick_pkg.
module uptick_timer
    import uptick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int SR_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              wr;
    logic              wr_cfg, wr_isr, wr_ier, wr_wake, wr_ctl, wr_cnt, wr_load, wr_trig, wr_match;
    logic [DATA_W-1:0] cfg_q, wake_q, load_q, match_q, cnt;
    ctl_t              ctl_q;
    logic [IRQ_NUM-1:0] ier_q, isr, set_evt;
    logic              ovf_evt, mat_evt, sr_busy, sr_fire;

    // Write strobes per register.
    always_comb begin
        wr       = bus_en && bus_we;
        wr_cfg   = wr && (bus_addr == ADDR_W'(OFF_CFG));
        wr_isr   = wr && (bus_addr == ADDR_W'(OFF_ISR));
        wr_ier   = wr && (bus_addr == ADDR_W'(OFF_IER));
        wr_wake  = wr && (bus_addr == ADDR_W'(OFF_WAKE));
        wr_ctl   = wr && (bus_addr == ADDR_W'(OFF_CTL));
        wr_cnt   = wr && (bus_addr == ADDR_W'(OFF_CNT));
        wr_load  = wr && (bus_addr == ADDR_W'(OFF_LOAD));
        wr_trig  = wr && (bus_addr == ADDR_W'(OFF_TRIG));
        wr_match = wr && (bus_addr == ADDR_W'(OFF_MATCH));
    end

    // Plain storage registers: config (request bit not stored), wake, load, match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            wake_q  <= '0;
            load_q  <= '0;
            match_q <= '0;
        end else begin
            if (wr_cfg)   cfg_q   <= bus_wdata & ~(DATA_W'(1) << CFG_SRST);
            if (wr_wake)  wake_q  <= bus_wdata;
            if (wr_load)  load_q  <= bus_wdata;
            if (wr_match) match_q <= bus_wdata;
        end
    end

    // Control register: cleared by soft reset, run drops on a non-reload wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= '0;
        else if (sr_fire)   ctl_q <= '0;
        else if (wr_ctl)    ctl_q <= '{cmp_en:  bus_wdata[CTL_CMP],
                                       auto_rl: bus_wdata[CTL_AUTO],
                                       run:     bus_wdata[CTL_RUN]};
        else if (ovf_evt && !ctl_q.auto_rl) ctl_q.run <= 1'b0;
    end

    // Interrupt enable register, cleared by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ier_q <= '0;
        else if (sr_fire)  ier_q <= '0;
        else if (wr_ier)   ier_q <= bus_wdata[IRQ_NUM-1:0];
    end

    uptick_softrst #(.CYC(SR_CYC)) u_srst (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (wr_cfg && bus_wdata[CFG_SRST]),
        .busy (sr_busy),
        .fire (sr_fire)
    );

    uptick_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run      (ctl_q.run),
        .auto_rl  (ctl_q.auto_rl),
        .cmp_en   (ctl_q.cmp_en),
        .cnt_wr   (wr_cnt),
        .cnt_wdata(bus_wdata),
        .trig     (wr_trig),
        .load_val (load_q),
        .match_val(match_q),
        .cnt      (cnt),
        .ovf_evt  (ovf_evt),
        .mat_evt  (mat_evt)
    );

    // Event vector in status-bit order.
    always_comb begin
        set_evt          = '0;
        set_evt[IRQ_OVF] = ovf_evt;
        set_evt[IRQ_MAT] = mat_evt;
    end

    uptick_intc #(.N(IRQ_NUM)) u_intc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_wr  (wr_isr),
        .clr_mask(bus_wdata[IRQ_NUM-1:0]),
        .ien     (ier_q),
        .isr     (isr),
        .irq     (irq)
    );

    // Read mux; trigger, write-pending and unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CFG):   begin
                bus_rdata = cfg_q;
                bus_rdata[CFG_SRST] = sr_busy;
            end
            ADDR_W'(OFF_STAT):  bus_rdata[STAT_DONE] = !sr_busy;
            ADDR_W'(OFF_ISR):   bus_rdata[IRQ_NUM-1:0] = isr;
            ADDR_W'(OFF_IER):   bus_rdata[IRQ_NUM-1:0] = ier_q;
            ADDR_W'(OFF_WAKE):  bus_rdata = wake_q;
            ADDR_W'(OFF_CTL):   begin
                bus_rdata[CTL_RUN]  = ctl_q.run;
                bus_rdata[CTL_AUTO] = ctl_q.auto_rl;
                bus_rdata[CTL_CMP]  = ctl_q.cmp_en;
            end
            ADDR_W'(OFF_CNT):   bus_rdata = cnt;
            ADDR_W'(OFF_LOAD):  bus_rdata = load_q;
            ADDR_W'(OFF_MATCH): bus_rdata = match_q;
            default:            bus_rdata = '0;
        endcase
    end

    AST_STOP_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ctl_q.auto_rl && !wr_ctl) |=> !ctl_q.run); // R3
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_isr && !wr_ier && !sr_fire) |=> irq); // R8
    AST_SR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_fire |=> (ctl_q == '0 && ier_q == '0)); // R9
    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && set_evt == '0 && !wr_ier) |=> !irq); // R8
endmodule

// File: tb/tb_uptick_timer.sv
// Scoreboard bench: driver tasks issue one access per cycle and queue the
// expected result; a monitor pops and compares late in the same cycle.
module tb_uptick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    typedef struct {
        int          kind;   // 1 = read data, 2 = irq pin
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    obs_kind = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    uptick_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic drive(input logic en, input logic we, input logic [7:0] a,
                         input logic [31:0] d, input logic tk, input int kind);
        @(posedge clk); #1;
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
        obs_kind = kind;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, 1'b1, a, d, 1'b0, 0);
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, 1'b1, a, d, 1'b1, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = 1; it.exp = e; it.tag = tag;
        q.push_back(it);
        drive(1'b1, 1'b0, a, 32'h0, 1'b0, 1);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.kind = 2; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        drive(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 2);
    endtask

    // Monitor: compare queued expectations late in each cycle.
    initial begin
        forever begin
            @(posedge clk); #6;
            if (obs_kind != 0 && q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = (it.kind == 2) ? {31'b0, irq} : bus_rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state and read-only / unmapped offsets
        rd(8'h24, 32'h0, "R10 ctl after reset");
        rd(8'h14, 32'h1, "R10 reset-done after reset");
        rd(8'h18, 32'h0, "R10 isr after reset");
        rd(8'h28, 32'h0, "R10 cnt after reset");
        chk_irq(1'b0, "R10 irq after reset");
        rd(8'h34, 32'h0, "R10 write-pending reads 0");
        rd(8'h30, 32'h0, "R10 trigger reads 0");
        rd(8'h00, 32'h0, "R10 unmapped reads 0");
        wr(8'h20, 32'h0000_0005);
        rd(8'h20, 32'h0000_0005, "R10 wake readback");

        // R1 counting and holding
        wr(8'h28, 32'd100);
        wr(8'h24, 32'h1);
        ticks(5);
        rd(8'h28, 32'd105, "R1 five ticks");
        idle(3);
        rd(8'h28, 32'd105, "R1 hold without tick");
        wr(8'h24, 32'h0);
        ticks(3);
        rd(8'h28, 32'd105, "R1 hold when stopped");

        // R2 autoreload with period 3
        wr(8'h2C, 32'hFFFF_FFFD);
        wr(8'h28, 32'hFFFF_FFFE);
        wr(8'h1C, 32'h2);
        wr(8'h24, 32'h3);
        ticks(1);
        rd(8'h28, 32'hFFFF_FFFF, "R2 before wrap");
        rd(8'h18, 32'h0, "R2 no overflow yet");
        chk_irq(1'b0, "R8 irq low before wrap");
        ticks(1);
        rd(8'h28, 32'hFFFF_FFFD, "R2 reload on wrap");
        rd(8'h18, 32'h2, "R2 overflow status");
        chk_irq(1'b1, "R8 irq on overflow");
        rd(8'h24, 32'h3, "R2 still running");
        ticks(3);
        rd(8'h28, 32'hFFFF_FFFD, "R2 period of 3 ticks");

        // R7 write-zero no effect, write-one clears
        wr(8'h18, 32'h0);
        rd(8'h18, 32'h2, "R7 write 0 keeps");
        chk_irq(1'b1, "R8 level held");
        wr(8'h18, 32'h2);
        rd(8'h18, 32'h0, "R7 write 1 clears");
        chk_irq(1'b0, "R8 irq drops on clear");

        // R3 one-shot stop
        wr(8'h24, 32'h1);
        wr(8'h28, 32'hFFFF_FFFF);
        ticks(1);
        rd(8'h28, 32'h0, "R3 zero after wrap");
        rd(8'h24, 32'h0, "R3 run cleared");
        rd(8'h18, 32'h2, "R3 overflow status");
        ticks(3);
        rd(8'h28, 32'h0, "R3 no further counting");
        wr(8'h18, 32'h2);

        // R4 counter write beats tick
        wr(8'h24, 32'h1);
        wr(8'h28, 32'd10);
        wr_tick(8'h28, 32'd50);
        rd(8'h28, 32'd50, "R4 write wins over tick");
        ticks(2);
        rd(8'h28, 32'd52, "R4 counting continues");

        // R5 trigger reload
        wr(8'h24, 32'h0);
        wr(8'h2C, 32'h0000_1234);
        wr(8'h30, 32'hDEAD_BEEF);
        rd(8'h28, 32'h0000_1234, "R5 trigger loads counter");

        // R6 compare match
        wr(8'h38, 32'h20);
        wr(8'h28, 32'h1E);
        wr(8'h1C, 32'h1);
        wr(8'h24, 32'h41);
        ticks(2);
        rd(8'h18, 32'h0, "R6 not yet set");
        rd(8'h18, 32'h1, "R6 match status");
        chk_irq(1'b1, "R8 irq on match");
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h1, "R7 set wins over clear");
        wr(8'h1C, 32'h0);
        chk_irq(1'b0, "R8 masked");
        rd(8'h18, 32'h1, "R8 status kept while masked");
        wr(8'h1C, 32'h1);
        chk_irq(1'b1, "R8 unmasked");
        wr(8'h24, 32'h1);
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h0, "R6 no match when compare off");
        chk_irq(1'b0, "R8 irq low after clear");

        // R9 soft reset sequence
        wr(8'h24, 32'h43);
        wr(8'h1C, 32'h3);
        wr(8'h10, 32'h0A);
        rd(8'h14, 32'h0, "R9 busy cycle 1");
        rd(8'h10, 32'h0A, "R9 request bit reads 1");
        rd(8'h14, 32'h0, "R9 busy cycle 3");
        rd(8'h14, 32'h0, "R9 busy cycle 4");
        rd(8'h14, 32'h1, "R9 done after 4 cycles");
        rd(8'h10, 32'h08, "R9 request bit self-clears");
        rd(8'h24, 32'h0, "R9 ctl cleared");
        rd(8'h1C, 32'h0, "R9 ier cleared");

        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule